// File: doc/BRIEF.md
# Compound-Rotation Channel-Value Shifter

This block is the cyclic alignment stage in front of the row processors of a layered LDPC decoder. Each parity-check submatrix is a shifted identity. Moving a block of Z soft channel values (each W bits, 5 by default) into or out of row order is therefore a pure cyclic rotation. The shifter performs that rotation in one registered cycle, using a logarithmic chain of conditional rotate stages.

The write-back path has no reverse rotator. The controller instead stores, for every use of a block column, a compound amount: the current submatrix shift minus the shift last applied to that column, modulo Z. Between subiterations the values therefore stay in memory in rotated order. When decoding finishes, an unload pass sends each column through this same shifter in reverse mode, using the last shift applied to that column, which restores natural order. Reverse rotation by s is carried out as forward rotation by (Z - s) mod Z. Subiterations of two frames may alternate freely, because the block holds no per-column state.

Top module: `chanrot_shifter`

## Requirements
- R1: While `rst_n` is low and after its release, until the first accepted input, `out_valid` is 0 and `out_vec` is all zeros.
- R2: Element i of a vector occupies bits [i*W +: W]. In process mode (`in_mode`=0) with amount s, one clock edge after `in_valid`, output element i equals input element (i+s) mod Z.
- R3: In unload mode (`in_mode`=1) with amount s, output element i equals input element (i-s) mod Z, one clock edge after `in_valid`.
- R4: An amount of 0 passes the vector through unchanged in either mode.
- R5: An amount of Z or more acts as that amount modulo Z, in both modes.
- R6: `out_valid` is `in_valid` delayed by one cycle. While `in_valid` is low, `out_vec` keeps its last value.
- R7: An unload with amount s restores a vector that was rotated in process mode by s.
- R8: Suppose each subiteration is fed the stored values with amount (s_new - s_prev) mod Z, and the results are written back unrotated. Then each output equals the natural-order data rotated by s_new. A final unload by the last shift returns natural order. This holds for two frames whose subiterations alternate.
- R9: Every value is carried at full width W. Rotation only moves elements: the XOR of all elements is the same at input and output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector and amount are valid this cycle |
| in_mode | input | 1 | 0 = process (forward), 1 = unload (reverse) |
| in_amt | input | $clog2(Z) | Rotation amount |
| in_vec | input | Z*W | Z channel values, element i at [i*W +: W] |
| out_valid | output | 1 | Output vector valid |
| out_vec | output | Z*W | Rotated vector, registered |

## Verification
A wrong rotate stage or a bad modulo reduction shows up at the output one cycle after the offending input, as misplaced elements. The damage appears only for amounts whose bit pattern selects that stage, so the amounts are drawn across the full input range, including values of Z and above. A fault in the compound scheme does not surface until a later subiteration or the final unload, when the recovered order differs from natural order. The two-frame sequence therefore compares every intermediate alignment against a model that applies forward and reverse rotations separately.

// File: rtl/chanrot_shifter.sv
module chanrot_shifter #(
  parameter int Z = 12,
  parameter int W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_mode,
  input  logic [$clog2(Z)-1:0] in_amt,
  input  logic [Z*W-1:0]       in_vec,
  output logic                 out_valid,
  output logic [Z*W-1:0]       out_vec
);
  localparam int SW = $clog2(Z);

  logic [SW-1:0] amt_m, eff;
  logic [W-1:0]  stg [0:SW][0:Z-1];
  logic [Z*W-1:0] rot;

  assign amt_m = SW'(32'(in_amt) % Z);
  assign eff   = !in_mode ? amt_m : (amt_m == '0 ? '0 : SW'(Z) - amt_m);

  for (genvar i = 0; i < Z; i++) begin : g_ld
    assign stg[0][i]     = in_vec[i*W +: W];
    assign rot[i*W +: W] = stg[SW][i];
  end

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int RK = (1 << k) % Z;
    for (genvar i = 0; i < Z; i++) begin : g_el
      assign stg[k+1][i] = eff[k] ? stg[k][(i + RK) % Z] : stg[k][i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_vec <= rot;
    end
  end

  function automatic logic [W-1:0] xfold(input logic [Z*W-1:0] v);
    logic [W-1:0] a;
    a = '0;
    for (int i = 0; i < Z; i++) a ^= v[i*W +: W];
    return a;
  endfunction

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R6
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || !in_valid) && !in_valid |=> $stable(out_vec));
  // R4
  zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_amt == '0 |=> out_vec == $past(in_vec));
  // R9
  content_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> xfold(out_vec) == $past(xfold(in_vec)));
endmodule

// File: tb/chanrot_shifter_tb.sv
module chanrot_shifter_tb_top;
  localparam int Z = 12;
  localparam int W = 5;
  localparam int SW = $clog2(Z);

  logic clk = 0, rst_n = 0, in_valid = 0, in_mode = 0;
  logic [SW-1:0] in_amt = '0;
  logic [Z*W-1:0] in_vec = '0;
  logic out_valid;
  logic [Z*W-1:0] out_vec;
  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  chanrot_shifter #(.Z(Z), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_amt(in_amt), .in_vec(in_vec), .out_valid(out_valid), .out_vec(out_vec));

  function automatic logic [Z*W-1:0] rot_fwd(input logic [Z*W-1:0] v, input int s);
    logic [Z*W-1:0] r;
    for (int i = 0; i < Z; i++) r[i*W +: W] = v[((i + s) % Z)*W +: W];
    return r;
  endfunction

  function automatic logic [Z*W-1:0] rot_rev(input logic [Z*W-1:0] v, input int s);
    logic [Z*W-1:0] r;
    for (int i = 0; i < Z; i++) r[i*W +: W] = v[((i - (s % Z) + Z) % Z)*W +: W];
    return r;
  endfunction

  function automatic logic [Z*W-1:0] rnd_vec();
    logic [Z*W-1:0] r;
    for (int i = 0; i < Z; i++) r[i*W +: W] = W'($urandom);
    return r;
  endfunction

  function automatic logic [Z*W-1:0] bump(input logic [Z*W-1:0] v);
    logic [Z*W-1:0] r;
    for (int i = 0; i < Z; i++) r[i*W +: W] = v[i*W +: W] + W'(1);
    return r;
  endfunction

  task automatic check(input string req, input logic [Z*W-1:0] got, input logic [Z*W-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic shift(input logic m, input int a, input logic [Z*W-1:0] v,
                       output logic [Z*W-1:0] res);
    @(negedge clk);
    in_valid = 1; in_mode = m; in_amt = SW'(a); in_vec = v;
    @(negedge clk);
    in_valid = 0;
    res = out_vec;
    n_tests++;
    if (out_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL R6: out_valid got %b expected 1", out_valid);
    end
  endtask

  initial begin
    logic [Z*W-1:0] v, r, held;
    logic [Z*W-1:0] nat [0:1];
    logic [Z*W-1:0] mem [0:1];
    int last [0:1];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1
    check("R1", {{(Z*W-1){1'b0}}, out_valid}, '0);
    check("R1", out_vec, '0);
    rst_n = 1;
    @(negedge clk);
    check("R1", {{(Z*W-1){1'b0}}, out_valid}, '0);
    check("R1", out_vec, '0);

    // R4 zero amount, both modes
    v = rnd_vec();
    shift(0, 0, v, r); check("R4", r, v);
    shift(1, 0, v, r); check("R4", r, v);

    // R9 full-width extremes
    for (int i = 0; i < Z; i++) v[i*W +: W] = (i % 2) ? '1 : W'(i);
    shift(0, 5, v, r); check("R9", r, rot_fwd(v, 5));

    // R2 / R3 / R7 directed and random
    for (int s = 1; s < Z; s++) begin
      v = rnd_vec();
      shift(0, s, v, r); check("R2", r, rot_fwd(v, s));
      shift(1, s, r, r); check("R7", r, v);
      shift(1, s, v, r); check("R3", r, rot_rev(v, s));
    end

    // R5 amounts at or above Z
    for (int s = Z; s < (1 << SW); s++) begin
      v = rnd_vec();
      shift(0, s, v, r); check("R5", r, rot_fwd(v, s % Z));
      shift(1, s, v, r); check("R5", r, rot_rev(v, s % Z));
    end

    // R6 hold while idle
    held = out_vec;
    @(negedge clk);
    in_vec = rnd_vec(); in_amt = 3;
    @(negedge clk);
    check("R6", out_vec, held);
    check("R6", {{(Z*W-1){1'b0}}, out_valid}, '0);

    // R8 compound rotations, two frames alternating
    for (int f = 0; f < 2; f++) begin
      nat[f] = rnd_vec(); mem[f] = nat[f]; last[f] = 0;
    end
    for (int it = 0; it < 40; it++) begin
      for (int f = 0; f < 2; f++) begin
        int sh;
        sh = int'($urandom % Z);
        if (it == 0 && f == 0) sh = Z - 1;
        shift(0, (sh - last[f] + Z) % Z, mem[f], r);
        check("R8", r, rot_fwd(nat[f], sh));
        mem[f] = bump(r);
        nat[f] = rot_rev(bump(rot_fwd(nat[f], sh)), sh);
        last[f] = sh;
      end
    end
    for (int f = 0; f < 2; f++) begin
      shift(1, last[f], mem[f], r);
      check("R8", r, nat[f]);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule